// File: doc/BRIEF.md
# Sideways ROM/RAM paging controller

This block sits between a small 8-bit CPU and the memories behind a 16 KB paged window. A bank register picks one of sixteen slots for that window. Slots 0 to 3 reach the motherboard ROM sockets. Slots 4 to 13 reach five 32 KB expansion sockets, two slots per socket. Slots 14 and 15 reach the two 16 KB halves of a 32 KB board RAM. When a socket reports that it is empty, reads fall back to a default image store that is addressed by slot and offset.

Two more registers extend this mapping. A RAM write-target register copies window writes into one half of board RAM while a ROM is still paged in. A shadow register sends reads from the upper part of main memory to board RAM. A separate overlay flag maps the low 8 KB of the window straight onto board RAM. When that flag is set, main-memory writes above 8 KB also go to board RAM.

All reads are combinational. Writes are single-cycle strobes towards the external memories. The only state inside the block is its control registers.

Top module: `sideways_pager`

## Requirements
- R1: After reset the bank is slot 0, the overlay flag is clear, and the RAM write-target and shadow registers are zero.
- R2: A register write is decoded on reg_addr[3:1]. Value 0 loads the bank register, value 1 loads the RAM write-target register, and value 2 loads the shadow register. Values 3 to 7 change nothing.
- R3: A bank write keeps only reg_wdata[3:0] as the slot number. It also latches reg_wdata[7] into the overlay flag.
- R4: For slots 0 to 3, sock_sel equals the slot and rom_addr is {1'b0, window offset}.
- R5: For slots 4 to 13, sock_sel is the slot with bit 0 cleared and rom_addr is {slot[0], window offset}.
- R6: For slots 0 to 13, a window read returns rom_rdata when sock_present[sock_sel] is 1. Otherwise it returns dflt_rdata, with dflt_addr = {slot, window offset}.
- R7: Slots 14 and 15 read board RAM at {slot[0], offset}. A window write to these slots never asserts rom_we.
- R8: A window write to slots 0 to 13 asserts rom_we. When the RAM write-target register holds 14 or 15, any window write also writes board RAM at {target[0], offset} with win_wdata. Any other target value writes nothing to board RAM.
- R9: While the overlay flag is set, window offsets below 0x2000 read and write board RAM at {1'b0, offset}. These accesses take priority over slot decoding and never assert rom_we.
- R10: When shadow bit 7 is set, main reads at main_addr of 0x2000 or above return board RAM at main_addr. All other main reads return mbram_rdata. The shadow bit does not steer main writes.
- R11: A main write at 0x2000 or above goes to board RAM when the overlay flag is set. Every other main write strobes mbram_we. Exactly one of the two strobes is raised.
- R12: With win_cs low, win_rdata is 0xFF. A main access is served only while win_cs is low; otherwise main_rdata is 0xFF. When no access is served, no write strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| win_cs | input | 1 | Paged-window access |
| win_we | input | 1 | Window write |
| win_addr | input | 14 | Window offset |
| win_wdata | input | 8 | Window write data |
| win_rdata | output | 8 | Window read data |
| main_cs | input | 1 | Main-memory access |
| main_we | input | 1 | Main write |
| main_addr | input | 15 | Main-memory offset |
| main_wdata | input | 8 | Main write data |
| main_rdata | output | 8 | Main read data |
| sock_sel | output | 4 | Selected ROM socket id |
| rom_addr | output | 15 | Address within the socket |
| rom_we | output | 1 | Socket write strobe |
| rom_wdata | output | 8 | Socket write data |
| rom_rdata | input | 8 | Socket read data |
| sock_present | input | 16 | Socket present flags, indexed by socket id |
| dflt_addr | output | 18 | Default image address |
| dflt_rdata | input | 8 | Default image read data |
| bram_addr | output | 15 | Board RAM address |
| bram_we | output | 1 | Board RAM write strobe |
| bram_wdata | output | 8 | Board RAM write data |
| bram_rdata | input | 8 | Board RAM read data |
| mbram_addr | output | 15 | Motherboard RAM address |
| mbram_we | output | 1 | Motherboard RAM write strobe |
| mbram_wdata | output | 8 | Motherboard RAM write data |
| mbram_rdata | input | 8 | Motherboard RAM read data |

## Verification
The bench focuses on the boundaries where routing changes.

- **Offsets 0x1FFF and 0x2000.** These sit either side of the overlay and shadow limits. A design that compared against the wrong limit would read the wrong memory, or would fire rom_we under the overlay.
- **Odd slots 5 and 13.** A design that dropped slot bit 0 would address the wrong 16 KB half of the socket.
- **Empty sockets.** A design that ignored the present flags would return socket data instead of the default image.
- **RAM write-target values 13, 14, 15 and 0x8E.** A design that tested only the low bits of the target would copy writes into board RAM when it should not.
- **A bank write of 0xF5.** This proves that the 4-bit slot masking keeps the overlay flag.
- **Ignored register groups, and window and main accesses in the same cycle.** A design that decoded too few address bits, or served both ports at once, would corrupt the register state or the board RAM address.

// File: rtl/pg_pkg.sv
package pg_pkg;
    localparam int DW       = 8;
    localparam int SLOT_W   = 4;
    localparam int WIN_AW   = 14;
    localparam int MAIN_AW  = 15;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              ovl;
        logic [DW-1:0]     ramsel;
        logic [DW-1:0]     shadow;
    } pg_regs_t;

    typedef enum logic [2:0] {
        GRP_BANK   = 3'd0,
        GRP_RAMSEL = 3'd1,
        GRP_SHADOW = 3'd2
    } pg_grp_e;
endpackage

// File: rtl/pg_regfile.sv
module pg_regfile
    import pg_pkg::*;
#(
    parameter int OVL_BIT = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [3:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output pg_regs_t        regs
);
    pg_regs_t regs_q;
    pg_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            unique case (reg_addr[3:1])
                GRP_BANK: begin
                    regs_d.slot = reg_wdata[SLOT_W-1:0];
                    regs_d.ovl  = reg_wdata[OVL_BIT];
                end
                GRP_RAMSEL: regs_d.ramsel = reg_wdata;
                GRP_SHADOW: regs_d.shadow = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;
endmodule

// File: rtl/pg_window.sv
module pg_window
    import pg_pkg::*;
#(
    parameter int MB_SLOTS    = 4,
    parameter int RAM_SLOT_LO = 14,
    parameter int OVL_BOUND   = 'h2000
) (
    input  pg_regs_t              regs,
    input  logic                  win_cs,
    input  logic                  win_we,
    input  logic [WIN_AW-1:0]     win_addr,
    output logic [DW-1:0]         win_rdata,
    output logic [SLOT_W-1:0]     sock_sel,
    output logic [WIN_AW:0]       rom_addr,
    output logic                  rom_we,
    input  logic [DW-1:0]         rom_rdata,
    input  logic [(1<<SLOT_W)-1:0] sock_present,
    output logic [SLOT_W+WIN_AW-1:0] dflt_addr,
    input  logic [DW-1:0]         dflt_rdata,
    output logic                  bram_en,
    output logic                  bram_we,
    output logic [WIN_AW:0]       bram_addr,
    input  logic [DW-1:0]         bram_rdata
);
    localparam logic [SLOT_W-1:0] MB_TOP   = SLOT_W'(MB_SLOTS);
    localparam logic [SLOT_W-1:0] RAM_LO   = SLOT_W'(RAM_SLOT_LO);
    localparam logic [DW-1:0]     RAM_PAIR = DW'(RAM_SLOT_LO);
    localparam logic [WIN_AW-1:0] OVL_TOP  = WIN_AW'(OVL_BOUND);

    logic slot_is_mb, slot_is_ram, ovl_hit, ram_wsel;

    always_comb begin
        slot_is_mb  = regs.slot < MB_TOP;
        slot_is_ram = regs.slot >= RAM_LO;
        ovl_hit     = regs.ovl && (win_addr < OVL_TOP);
        ram_wsel    = regs.ramsel[DW-1:1] == RAM_PAIR[DW-1:1];

        sock_sel  = slot_is_mb ? regs.slot : {regs.slot[SLOT_W-1:1], 1'b0};
        rom_addr  = {slot_is_mb ? 1'b0 : regs.slot[0], win_addr};
        dflt_addr = {regs.slot, win_addr};

        win_rdata = '1;
        rom_we    = 1'b0;
        bram_en   = 1'b0;
        bram_we   = 1'b0;
        bram_addr = {1'b0, win_addr};

        if (win_cs) begin
            if (ovl_hit) begin
                bram_en   = 1'b1;
                bram_we   = win_we;
                bram_addr = {1'b0, win_addr};
                win_rdata = bram_rdata;
            end else begin
                if (slot_is_ram) begin
                    bram_en   = 1'b1;
                    bram_addr = {regs.slot[0], win_addr};
                    win_rdata = bram_rdata;
                end else begin
                    rom_we    = win_we;
                    win_rdata = sock_present[sock_sel] ? rom_rdata : dflt_rdata;
                end
                if (win_we && ram_wsel) begin
                    bram_en   = 1'b1;
                    bram_we   = 1'b1;
                    bram_addr = {regs.ramsel[0], win_addr};
                end
            end
        end
    end
endmodule

// File: rtl/pg_main.sv
module pg_main
    import pg_pkg::*;
#(
    parameter int SHADOW_BIT   = 7,
    parameter int SHADOW_BOUND = 'h2000
) (
    input  pg_regs_t             regs,
    input  logic                 go,
    input  logic                 main_we,
    input  logic [MAIN_AW-1:0]   main_addr,
    output logic [DW-1:0]        main_rdata,
    input  logic [DW-1:0]        mbram_rdata,
    input  logic [DW-1:0]        bram_rdata,
    output logic                 bram_en,
    output logic                 bram_we,
    output logic                 mbram_we
);
    localparam logic [MAIN_AW-1:0] UPPER = MAIN_AW'(SHADOW_BOUND);

    logic upper, shadow_rd, ovl_wr;

    always_comb begin
        upper     = main_addr >= UPPER;
        shadow_rd = regs.shadow[SHADOW_BIT] && upper;
        ovl_wr    = regs.ovl && upper;

        main_rdata = '1;
        bram_en    = 1'b0;
        bram_we    = 1'b0;
        mbram_we   = 1'b0;
        if (go) begin
            if (main_we) begin
                bram_en  = ovl_wr;
                bram_we  = ovl_wr;
                mbram_we = !ovl_wr;
            end else begin
                bram_en    = shadow_rd;
                main_rdata = shadow_rd ? bram_rdata : mbram_rdata;
            end
        end
    end
endmodule

// File: rtl/sideways_pager.sv
module sideways_pager
    import pg_pkg::*;
#(
    parameter int MB_SLOTS    = 4,
    parameter int RAM_SLOT_LO = 14,
    parameter int LOW_BOUND   = 'h2000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [3:0]                  reg_addr,
    input  logic [DW-1:0]               reg_wdata,
    input  logic                        win_cs,
    input  logic                        win_we,
    input  logic [WIN_AW-1:0]           win_addr,
    input  logic [DW-1:0]               win_wdata,
    output logic [DW-1:0]               win_rdata,
    input  logic                        main_cs,
    input  logic                        main_we,
    input  logic [MAIN_AW-1:0]          main_addr,
    input  logic [DW-1:0]               main_wdata,
    output logic [DW-1:0]               main_rdata,
    output logic [SLOT_W-1:0]           sock_sel,
    output logic [WIN_AW:0]             rom_addr,
    output logic                        rom_we,
    output logic [DW-1:0]               rom_wdata,
    input  logic [DW-1:0]               rom_rdata,
    input  logic [(1<<SLOT_W)-1:0]      sock_present,
    output logic [SLOT_W+WIN_AW-1:0]    dflt_addr,
    input  logic [DW-1:0]               dflt_rdata,
    output logic [MAIN_AW-1:0]          bram_addr,
    output logic                        bram_we,
    output logic [DW-1:0]               bram_wdata,
    input  logic [DW-1:0]               bram_rdata,
    output logic [MAIN_AW-1:0]          mbram_addr,
    output logic                        mbram_we,
    output logic [DW-1:0]               mbram_wdata,
    input  logic [DW-1:0]               mbram_rdata
);
    pg_regs_t          regs;
    logic              w_bram_en, w_bram_we, m_bram_en, m_bram_we;
    logic [WIN_AW:0]   w_bram_addr;
    logic              main_go;

    assign main_go = main_cs && !win_cs;

    pg_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .regs      (regs)
    );

    pg_window #(
        .MB_SLOTS    (MB_SLOTS),
        .RAM_SLOT_LO (RAM_SLOT_LO),
        .OVL_BOUND   (LOW_BOUND)
    ) u_win (
        .regs         (regs),
        .win_cs       (win_cs),
        .win_we       (win_we),
        .win_addr     (win_addr),
        .win_rdata    (win_rdata),
        .sock_sel     (sock_sel),
        .rom_addr     (rom_addr),
        .rom_we       (rom_we),
        .rom_rdata    (rom_rdata),
        .sock_present (sock_present),
        .dflt_addr    (dflt_addr),
        .dflt_rdata   (dflt_rdata),
        .bram_en      (w_bram_en),
        .bram_we      (w_bram_we),
        .bram_addr    (w_bram_addr),
        .bram_rdata   (bram_rdata)
    );

    pg_main #(
        .SHADOW_BOUND (LOW_BOUND)
    ) u_main (
        .regs        (regs),
        .go          (main_go),
        .main_we     (main_we),
        .main_addr   (main_addr),
        .main_rdata  (main_rdata),
        .mbram_rdata (mbram_rdata),
        .bram_rdata  (bram_rdata),
        .bram_en     (m_bram_en),
        .bram_we     (m_bram_we),
        .mbram_we    (mbram_we)
    );

    assign bram_addr   = w_bram_en ? MAIN_AW'(w_bram_addr) : main_addr;
    assign bram_we     = w_bram_we || m_bram_we;
    assign bram_wdata  = w_bram_en ? win_wdata : main_wdata;
    assign rom_wdata   = win_wdata;
    assign mbram_addr  = main_addr;
    assign mbram_wdata = main_wdata;

    logic unused_m_bram_en;
    assign unused_m_bram_en = m_bram_en;
endmodule

// File: rtl/pg_checker.sv
module pg_checker
    import pg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [3:0]           reg_addr,
    input logic [DW-1:0]        reg_wdata,
    input pg_regs_t             regs,
    input logic                 win_cs,
    input logic                 win_we,
    input logic [WIN_AW-1:0]    win_addr,
    input logic [DW-1:0]        win_rdata,
    input logic                 main_cs,
    input logic                 main_we,
    input logic                 rom_we,
    input logic                 bram_we,
    input logic                 mbram_we
);
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr[3:1] == 3'd0 |=> regs.slot == $past(reg_wdata[3:0]) && regs.ovl == $past(reg_wdata[7])); // R3

    AST_REG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr[3:1] >= 3'd3 |=> $stable(regs)); // R2

    AST_OVL_NO_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        win_cs && win_we && regs.ovl && win_addr < 14'h2000 |-> !rom_we); // R9

    AST_RAMSLOT_NO_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        win_cs && regs.slot >= 4'd14 |-> !rom_we); // R7

    AST_MAIN_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        main_cs && main_we && !win_cs |-> $countones({bram_we, mbram_we}) == 1); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !win_cs && !main_cs |-> !rom_we && !bram_we && !mbram_we && win_rdata == 8'hFF); // R12
endmodule

bind sideways_pager pg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .regs      (regs),
    .win_cs    (win_cs),
    .win_we    (win_we),
    .win_addr  (win_addr),
    .win_rdata (win_rdata),
    .main_cs   (main_cs),
    .main_we   (main_we),
    .rom_we    (rom_we),
    .bram_we   (bram_we),
    .mbram_we  (mbram_we)
);

// File: tb/sideways_pager_test.sv
module sideways_pager_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic        win_cs, win_we;
    logic [13:0] win_addr;
    logic [7:0]  win_wdata, win_rdata;
    logic        main_cs, main_we;
    logic [14:0] main_addr;
    logic [7:0]  main_wdata, main_rdata;
    logic [3:0]  sock_sel;
    logic [14:0] rom_addr;
    logic        rom_we;
    logic [7:0]  rom_wdata, rom_rdata;
    logic [15:0] sock_present;
    logic [17:0] dflt_addr;
    logic [7:0]  dflt_rdata;
    logic [14:0] bram_addr;
    logic        bram_we;
    logic [7:0]  bram_wdata, bram_rdata;
    logic [14:0] mbram_addr;
    logic        mbram_we;
    logic [7:0]  mbram_wdata, mbram_rdata;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_f(input int tagv, input int a);
        return 8'((tagv * 53) ^ (a * 7) ^ (a >> 6));
    endfunction

    assign rom_rdata   = mem_f(100 + int'(sock_sel), int'(rom_addr));
    assign dflt_rdata  = mem_f(200, int'(dflt_addr));
    assign bram_rdata  = mem_f(300, int'(bram_addr));
    assign mbram_rdata = mem_f(400, int'(mbram_addr));

    sideways_pager uut (.*);

    int checks = 0, errors = 0;
    int r_slot, r_ovl, r_ramsel, r_shadow;
    bit done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            r_slot <= 0; r_ovl <= 0; r_ramsel <= 0; r_shadow <= 0;
        end else if (reg_wr) begin
            case (int'(reg_addr) / 2)
                0: begin r_slot <= int'(reg_wdata) % 16; r_ovl <= int'(reg_wdata) / 128; end
                1: r_ramsel <= int'(reg_wdata);
                2: r_shadow <= int'(reg_wdata);
                default: ;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        int off, sock, ra, exp_w, exp_bwe, exp_rwe, ma;
        bit ovl_hit, tsel;
        off  = int'(win_addr);
        ma   = int'(main_addr);
        tsel = (r_ramsel == 14 || r_ramsel == 15);
        ovl_hit = (r_ovl == 1) && off < 'h2000;
        exp_rwe = 0; exp_bwe = 0; exp_w = 'hFF;
        if (win_cs) begin
            if (ovl_hit) begin
                exp_w = int'(mem_f(300, off));
                exp_bwe = win_we;
                chk("R9 window rdata", int'(win_rdata), exp_w);
                if (win_we) chk("R9 bram_addr", int'(bram_addr), off);
            end else begin
                if (r_slot >= 14) begin
                    if (!win_we) chk("R7 window rdata", int'(win_rdata), int'(mem_f(300, (r_slot % 2) * 16384 + off)));
                end else begin
                    sock = (r_slot < 4) ? r_slot : (r_slot / 2) * 2;
                    ra   = (r_slot < 4) ? off : (r_slot % 2) * 16384 + off;
                    exp_rwe = win_we;
                    chk(r_slot < 4 ? "R4 sock_sel" : "R5 sock_sel", int'(sock_sel), sock);
                    chk(r_slot < 4 ? "R4 rom_addr" : "R5 rom_addr", int'(rom_addr), ra);
                    if (!win_we) begin
                        if (sock_present[sock])
                            chk("R6 present rdata", int'(win_rdata), int'(mem_f(100 + sock, ra)));
                        else begin
                            chk("R6 dflt_addr", int'(dflt_addr), r_slot * 16384 + off);
                            chk("R6 fallback rdata", int'(win_rdata), int'(mem_f(200, r_slot * 16384 + off)));
                        end
                    end
                end
                if (win_we && tsel) begin
                    exp_bwe = 1;
                    chk("R8 bram_addr", int'(bram_addr), (r_ramsel % 2) * 16384 + off);
                    chk("R8 bram_wdata", int'(bram_wdata), int'(win_wdata));
                end
            end
            chk(ovl_hit ? "R9 rom_we" : (r_slot >= 14 ? "R7 rom_we" : "R8 rom_we"), int'(rom_we), exp_rwe);
            chk(ovl_hit ? "R9 bram_we" : "R8 bram_we", int'(bram_we), exp_bwe);
            chk("R12 main blocked", int'(main_rdata), 'hFF);
            chk("R12 mbram_we blocked", int'(mbram_we), 0);
        end else begin
            chk("R12 idle win_rdata", int'(win_rdata), 'hFF);
            chk("R12 idle rom_we", int'(rom_we), 0);
            if (main_cs && !main_we) begin
                if ((r_shadow / 128) == 1 && ma >= 'h2000)
                    chk("R10 shadow rdata", int'(main_rdata), int'(mem_f(300, ma)));
                else
                    chk("R10 main rdata", int'(main_rdata), int'(mem_f(400, ma)));
                chk("R10 no write", int'(bram_we) + int'(mbram_we), 0);
            end else if (main_cs && main_we) begin
                if (r_ovl == 1 && ma >= 'h2000) begin
                    chk("R11 bram_we", int'(bram_we), 1);
                    chk("R11 bram_addr", int'(bram_addr), ma);
                    chk("R11 bram_wdata", int'(bram_wdata), int'(main_wdata));
                    chk("R11 mbram_we", int'(mbram_we), 0);
                end else begin
                    chk("R11 mbram_we", int'(mbram_we), 1);
                    chk("R11 bram_we", int'(bram_we), 0);
                end
            end else begin
                chk("R12 idle main_rdata", int'(main_rdata), 'hFF);
                chk("R12 idle strobes", int'(bram_we) + int'(mbram_we), 0);
            end
        end
    endtask

    task automatic quiet();
        reg_wr = 0; win_cs = 0; win_we = 0; main_cs = 0; main_we = 0;
    endtask

    task automatic step();
        #2;
        compare();
        @(negedge clk);
        quiet();
    endtask

    task automatic wreg(input int a, input int d);
        reg_wr = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
        step();
    endtask

    task automatic wacc(input int we, input int a, input int d);
        win_cs = 1; win_we = 1'(we); win_addr = 14'(a); win_wdata = 8'(d);
        step();
    endtask

    task automatic macc(input int we, input int a, input int d);
        main_cs = 1; main_we = 1'(we); main_addr = 15'(a); main_wdata = 8'(d);
        step();
    endtask

    initial begin
        #150000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        quiet();
        reg_addr = 0; reg_wdata = 0; win_addr = 0; win_wdata = 0;
        main_addr = 0; main_wdata = 0; sock_present = 16'h1555;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state seen through the ports
        win_cs = 1; win_addr = 14'h0123; #2;
        chk("R1 reset sock_sel", int'(sock_sel), 0);
        chk("R1 reset rom_addr", int'(rom_addr), 'h0123);
        win_cs = 0; main_cs = 1; main_addr = 15'h7000; #1;
        chk("R1 reset no shadow", int'(main_rdata), int'(mem_f(400, 'h7000)));
        @(negedge clk); quiet();
        // R4 / R5 / R6 slot walk
        for (int s = 0; s < 16; s++) begin
            wreg(0, s);
            wacc(0, 'h0000, 0);
            wacc(0, 'h3FFF, 0);
            wacc(1, 'h1234, s);
        end
        sock_present = 16'h0000;
        wreg(0, 5);  wacc(0, 'h0042, 0);
        wreg(0, 13); wacc(0, 'h2001, 0);
        sock_present = 16'hFFFF;
        // R8 write-target values
        foreach (sock_present[i]) begin end
        wreg(2, 13); wreg(0, 2); wacc(1, 'h0100, 'hA1);
        wreg(2, 14); wacc(1, 'h0100, 'hA2);
        wreg(2, 15); wacc(1, 'h3FFF, 'hA3);
        wreg(2, 'h8E); wacc(1, 'h0200, 'hA4);
        wreg(2, 14); wreg(0, 15); wacc(1, 'h0300, 'hA5);
        // R3: masking keeps the overlay flag
        wreg(0, 'hF5);
        wacc(0, 'h2000, 0);
        chk("R3 slot masked", int'(sock_sel), 4);
        wacc(0, 'h1FFF, 0);
        wacc(1, 'h1FFF, 'h5C);
        wacc(1, 'h2000, 'h5D);
        // R2: ignored groups and alternate offsets
        wreg(6, 'h09); wreg(15, 'h0A);
        wacc(0, 'h2800, 0);
        wreg(1, 'h03);
        wacc(0, 'h2800, 0);
        chk("R2 odd offset hits bank", int'(sock_sel), 3);
        wreg(5, 'h80); macc(0, 'h2000, 0); macc(0, 'h1FFF, 0);
        wreg(4, 'h00); macc(0, 'h2000, 0);
        wreg(3, 'h0F); wacc(1, 'h0010, 'h11);
        // R10 / R11 main side
        wreg(0, 'h00); wreg(4, 'h80);
        macc(1, 'h2000, 'h33); macc(1, 'h7FFF, 'h34);
        wreg(0, 'h80);
        macc(1, 'h2000, 'h35); macc(1, 'h1FFF, 'h36); macc(0, 'h6000, 0);
        // R12 both ports at once
        win_cs = 1; win_addr = 14'h2222; main_cs = 1; main_we = 1; main_addr = 15'h4000; step();
        step();
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int k;
            k = int'($urandom % 8);
            if (n % 50 == 0) sock_present = 16'($urandom);
            if (k == 0) begin
                reg_wr = 1; reg_addr = 4'($urandom); reg_wdata = 8'($urandom);
            end else begin
                win_cs = (k < 5); win_we = 1'($urandom);
                win_addr = ($urandom % 2) ? 14'($urandom) : 14'('h1FFE + $urandom % 4);
                win_wdata = 8'($urandom);
                main_cs = (k >= 4); main_we = 1'($urandom);
                main_addr = ($urandom % 2) ? 15'($urandom) : 15'('h1FFE + $urandom % 4);
                main_wdata = 8'($urandom);
            end
            step();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule